// File: doc/BRIEF.md
# Open-Load Fault Supervisor

This block watches the digital comparator flags of a multi-channel constant-current LED driver and decides, cycle by cycle, which channels may run, which must fall back to a low current, and whether the open-drain diagnostic line is pulled low. It filters the slow fault indications (per-channel open load, an externally forced diagnostic line, a shorted current-set reference) through persistence counters that need the condition to stay stable for a full filter window, both to latch and to release. It also keeps sticky temperature flags and a per-channel fault register that is cleared by a read strobe.

Two diagnostic modes act on the outputs. In detect-only mode a latched open load only pulls the diagnostic line low. In auto-recovery mode the faulty channel is held at low current and every other channel is switched off. When the fault recovers, the diagnostic line is released one cycle before the channels return. In this mode an externally forced low diagnostic line shuts every channel and raises a low-power request. All pins are plain level-sensitive control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

The filter window is `FILT_TICKS` ticks of an internal divider that pulses every `TICK_DIV` clocks. A real part sizes these so that the window is 10 ms.

Top module: `dfs_supervisor`

## Requirements
- R1: A per-channel open load, an externally forced diagnostic line and a reference short each set their latched flag only after the raw condition has held for `FILT_TICKS` consecutive ticks, and clear only after it has been absent for `FILT_TICKS` consecutive ticks. Any return of the raw input to the latched value before that restarts the count.
- R2: The warning flag `st_tw` and shutdown flag `st_tsd` set in the cycle after their comparator is high. They clear only once the flag has been read (`status_rd`) and the matching cool-down input (`tw_cool`/`tsd_cool`) is high with the comparator low.
- R3: Bit i of `fault_vec` is 1 while channel i has a latched open load. It stays 1 after recovery until a `fault_rd` pulse clears the whole register in the next cycle.
- R4: The `diag_mode` input encodes 00 = no diagnosis, 01 = detect-only, 10 = auto-recovery, 11 = keep the previous mode. It takes effect in the next cycle, and the mode after reset is no diagnosis.
- R5: In detect-only mode a latched open load pulls `diag_pull_low` high and leaves `ch_on` equal to `ch_req`. An externally forced diagnostic line sets no flag and changes no output.
- R6: In auto-recovery mode a latched open load on channel i drives `ch_low_cur` to one-hot bit i and `ch_on` to 0. On recovery `diag_pull_low` drops in the cycle the fault clears, while `ch_on` stays 0 for that cycle and equals `ch_req` in the next.
- R7: In auto-recovery mode a filtered external force (diagnostic pin sensed low while the block is not pulling it) sets `st_diagerr`, forces `ch_on` and `ch_low_cur` to 0 and raises `low_power`.
- R8: Open-load and external-force filtering run only while `diagen` is high and a diagnostic mode is active. Latched flags keep their value when `diagen` falls.
- R9: `uv` forces `ch_on` and `ch_low_cur` to 0 in the same cycle. A latched reference short or thermal shutdown also forces them to 0 and pulls `diag_pull_low`.
- R10: `st_uv` and `st_diag_range` follow `uv` and `diagen` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| diag_mode | input | 2 | Mode request (00 none, 01 detect, 10 auto, 11 keep) |
| ch_req | input | NCH | Channels requested on by configuration |
| ol_raw | input | NCH | Raw per-channel open-load comparator flags |
| diag_pin_low | input | 1 | Diagnostic pin sensed low |
| iset_short | input | 1 | Raw reference-short comparator |
| uv | input | 1 | Supply under-voltage comparator |
| diagen | input | 1 | Diagnostic-enable comparator |
| tw_cmp | input | 1 | Temperature-warning comparator |
| tw_cool | input | 1 | Temperature below warning threshold minus hysteresis |
| tsd_cmp | input | 1 | Thermal-shutdown comparator |
| tsd_cool | input | 1 | Temperature below shutdown threshold minus hysteresis |
| status_rd | input | 1 | Status register read strobe |
| fault_rd | input | 1 | Fault register read strobe |
| st_ol | output | 1 | Any channel has a latched open load |
| st_diagerr | output | 1 | Latched external force of the diagnostic line |
| st_iset_sc | output | 1 | Latched reference short |
| st_tw | output | 1 | Sticky temperature warning |
| st_tsd | output | 1 | Sticky thermal shutdown |
| st_uv | output | 1 | Under-voltage status |
| st_diag_range | output | 1 | Diagnostic-enable status |
| fault_vec | output | NCH | Per-channel fault register |
| diag_pull_low | output | 1 | Open-drain pull-down enable for the diagnostic pin |
| ch_on | output | NCH | Channels at full programmed current |
| ch_low_cur | output | NCH | Channels held at recovery low current |
| low_power | output | 1 | Low-power state request |

## Verification
The bench targets the filter boundaries. One case breaks a condition after most of the window and restarts it, which catches a design that accumulates ticks instead of restarting: such a design latches too early. Another case holds a recovered channel's fault bit until a read, which a design that mirrors live state would drop. For auto-recovery the bench samples the exact cycle where the diagnostic line releases and checks that the channels are still off, because a design that releases both together resumes a cycle early. Further cases read a temperature flag before cooling and cool before reading, force the diagnostic line in detect-only mode, drop the enable comparator under a latched fault, and use mode code 11 to catch a design that decodes it as a mode of its own.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  typedef enum logic [1:0] {
    DM_NONE   = 2'b00,
    DM_DETECT = 2'b01,
    DM_AUTO   = 2'b10,
    DM_KEEP   = 2'b11
  } diag_mode_e;

  function automatic logic mode_active(input diag_mode_e m);
    return (m == DM_DETECT) || (m == DM_AUTO);
  endfunction
endpackage

// File: rtl/dfs_tick_gen.sv
module dfs_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/dfs_persist_filter.sv
// Latches raw only after it has differed from the latched value for
// FILT_TICKS consecutive ticks; any agreement restarts the count.
module dfs_persist_filter #(
  parameter int FILT_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic raw,
  output logic state
);
  localparam int CW = (FILT_TICKS > 1) ? $clog2(FILT_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      state_q <= 1'b0;
    end else if (!run || (raw == state_q)) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        state_q <= raw;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign state = state_q;
endmodule

// File: rtl/dfs_sticky_flag.sv
// Sets on comparator; clears once read and cooled with comparator low.
module dfs_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp,
  input  logic cool,
  input  logic rd,
  output logic flag
);
  logic flag_q, seen_q;
  logic clr;

  assign clr = flag_q && !cmp && cool && (rd || seen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (cmp) begin
        flag_q <= 1'b1;
      end else if (clr) begin
        flag_q <= 1'b0;
      end
      if (!flag_q || clr) begin
        seen_q <= 1'b0;
      end else if (rd) begin
        seen_q <= 1'b1;
      end
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/dfs_supervisor.sv
module dfs_supervisor
  import dfs_pkg::*;
#(
  parameter int NCH        = 12,
  parameter int TICK_DIV   = 4,
  parameter int FILT_TICKS = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     diag_mode,
  input  logic [NCH-1:0] ch_req,
  input  logic [NCH-1:0] ol_raw,
  input  logic           diag_pin_low,
  input  logic           iset_short,
  input  logic           uv,
  input  logic           diagen,
  input  logic           tw_cmp,
  input  logic           tw_cool,
  input  logic           tsd_cmp,
  input  logic           tsd_cool,
  input  logic           status_rd,
  input  logic           fault_rd,
  output logic           st_ol,
  output logic           st_diagerr,
  output logic           st_iset_sc,
  output logic           st_tw,
  output logic           st_tsd,
  output logic           st_uv,
  output logic           st_diag_range,
  output logic [NCH-1:0] fault_vec,
  output logic           diag_pull_low,
  output logic [NCH-1:0] ch_on,
  output logic [NCH-1:0] ch_low_cur,
  output logic           low_power
);
  diag_mode_e     mode_q;
  logic           tick;
  logic           diag_run, ext_run;
  logic [NCH-1:0] ol_filt, ol_prev_q;
  logic           any_ol, hold_q;
  logic           ext_raw, ext_filt, iset_filt;
  logic           kill_all;
  logic [NCH-1:0] fault_q;

  // R4: mode register, code 11 keeps the previous mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= DM_NONE;
    end else if (diag_mode_e'(diag_mode) != DM_KEEP) begin
      mode_q <= diag_mode_e'(diag_mode);
    end
  end

  dfs_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  // R8: diagnosis only with the enable comparator high and a mode active
  assign diag_run = diagen && mode_active(mode_q);
  assign ext_run  = diagen && (mode_q == DM_AUTO);

  for (genvar i = 0; i < NCH; i++) begin : g_ol
    dfs_persist_filter #(.FILT_TICKS(FILT_TICKS)) ol_f (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(diag_run),
      .raw(ol_raw[i]), .state(ol_filt[i])
    );
  end

  // External force: pin low while this block is not pulling it
  assign ext_raw = diag_pin_low && !diag_pull_low;

  dfs_persist_filter #(.FILT_TICKS(FILT_TICKS)) ext_f (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ext_run),
    .raw(ext_raw), .state(ext_filt)
  );

  dfs_persist_filter #(.FILT_TICKS(FILT_TICKS)) iset_f (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(1'b1),
    .raw(iset_short), .state(iset_filt)
  );

  dfs_sticky_flag tw_i (
    .clk(clk), .rst_n(rst_n), .cmp(tw_cmp), .cool(tw_cool),
    .rd(status_rd), .flag(st_tw)
  );

  dfs_sticky_flag tsd_i (
    .clk(clk), .rst_n(rst_n), .cmp(tsd_cmp), .cool(tsd_cool),
    .rd(status_rd), .flag(st_tsd)
  );

  assign any_ol = |ol_filt;

  // R3: fault register, cleared on read, refilled by latched faults
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q   <= '0;
      hold_q    <= 1'b0;
      ol_prev_q <= '0;
    end else begin
      fault_q   <= (fault_rd ? '0 : fault_q) | ol_filt;
      hold_q    <= any_ol;
      ol_prev_q <= ol_filt;
    end
  end

  assign kill_all      = uv || iset_filt || st_tsd;
  assign diag_pull_low = any_ol || iset_filt || st_tsd;

  // R6 R7 R9: channel override
  always_comb begin
    ch_on      = ch_req;
    ch_low_cur = '0;
    low_power  = 1'b0;
    if (kill_all) begin
      ch_on = '0;
    end else if (mode_q == DM_AUTO && ext_filt) begin
      ch_on     = '0;
      low_power = 1'b1;
    end else if (mode_q == DM_AUTO && (any_ol || hold_q)) begin
      ch_on      = '0;
      ch_low_cur = ol_filt | ol_prev_q;
    end
  end

  assign st_ol         = any_ol;
  assign st_diagerr    = ext_filt;
  assign st_iset_sc    = iset_filt;
  assign st_uv         = uv;
  assign st_diag_range = diagen;
  assign fault_vec     = fault_q;
endmodule

// File: rtl/dfs_supervisor_chk.sv
module dfs_supervisor_chk #(
  parameter int NCH = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           uv,
  input logic           tw_cool,
  input logic           tsd_cool,
  input logic           fault_rd,
  input logic           st_ol,
  input logic           st_tw,
  input logic           st_tsd,
  input logic           st_iset_sc,
  input logic [NCH-1:0] fault_vec,
  input logic           diag_pull_low,
  input logic [NCH-1:0] ch_on,
  input logic [NCH-1:0] ch_low_cur,
  input logic           low_power
);
  // R9
  uv_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv |-> (ch_on == '0) && (ch_low_cur == '0));
  // R9
  iset_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_iset_sc |-> diag_pull_low && (ch_on == '0));
  // R3
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_rd && !st_ol) |=> (fault_vec == '0));
  // R2
  tw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_tw) |-> $past(tw_cool));
  // R2
  tsd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_tsd) |-> $past(tsd_cool));
  // R7
  low_power_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> (ch_on == '0) && (ch_low_cur == '0));
  // R6
  low_cur_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_on & ch_low_cur) == '0);
endmodule

bind dfs_supervisor dfs_supervisor_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .uv(uv), .tw_cool(tw_cool), .tsd_cool(tsd_cool),
  .fault_rd(fault_rd), .st_ol(st_ol), .st_tw(st_tw), .st_tsd(st_tsd),
  .st_iset_sc(st_iset_sc), .fault_vec(fault_vec),
  .diag_pull_low(diag_pull_low), .ch_on(ch_on), .ch_low_cur(ch_low_cur),
  .low_power(low_power)
);

// File: tb/dfs_supervisor_tb.sv
module dfs_supervisor_tb_top;
  localparam int NCH = 12;
  localparam logic [NCH-1:0] REQ = 12'hA5F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] diag_mode = 2'b00;
  logic [NCH-1:0] ch_req = REQ, ol_raw = '0;
  logic ext_force = 1'b0;
  logic iset_short = 0, uv = 0, diagen = 0;
  logic tw_cmp = 0, tw_cool = 0, tsd_cmp = 0, tsd_cool = 0;
  logic status_rd = 0, fault_rd = 0;
  logic st_ol, st_diagerr, st_iset_sc, st_tw, st_tsd, st_uv, st_diag_range;
  logic [NCH-1:0] fault_vec, ch_on, ch_low_cur;
  logic diag_pull_low, low_power, diag_pin_low;
  int checks = 0, errors = 0;
  bit done = 0;

  assign diag_pin_low = diag_pull_low | ext_force;

  always #10 clk = ~clk;

  dfs_supervisor #(.NCH(NCH), .TICK_DIV(4), .FILT_TICKS(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .diag_mode(diag_mode), .ch_req(ch_req),
    .ol_raw(ol_raw), .diag_pin_low(diag_pin_low), .iset_short(iset_short),
    .uv(uv), .diagen(diagen), .tw_cmp(tw_cmp), .tw_cool(tw_cool),
    .tsd_cmp(tsd_cmp), .tsd_cool(tsd_cool), .status_rd(status_rd),
    .fault_rd(fault_rd), .st_ol(st_ol), .st_diagerr(st_diagerr),
    .st_iset_sc(st_iset_sc), .st_tw(st_tw), .st_tsd(st_tsd), .st_uv(st_uv),
    .st_diag_range(st_diag_range), .fault_vec(fault_vec),
    .diag_pull_low(diag_pull_low), .ch_on(ch_on), .ch_low_cur(ch_low_cur),
    .low_power(low_power)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_fault_rd();
    fault_rd = 1; cyc(1); fault_rd = 0;
  endtask

  task automatic t_reset();
    chk("R10 reset st_uv", st_uv, 0);
    chk("R1 reset flags", {st_ol, st_diagerr, st_iset_sc}, 0);
    chk("R2 reset thermal", {st_tw, st_tsd}, 0);
    chk("R3 reset fault_vec", fault_vec, 0);
    chk("R9 reset ch_on follows req", ch_on, REQ);
    chk("R9 reset pull", diag_pull_low, 0);
  endtask

  task automatic t_detect_filter();
    diag_mode = 2'b01; diagen = 1; cyc(2);
    chk("R10 diag_range", st_diag_range, 1);
    ol_raw[3] = 1; cyc(30);
    ol_raw[3] = 0; cyc(3);
    ol_raw[3] = 1; cyc(30);
    chk("R1 restart no early latch", st_ol, 0);
    cyc(20);
    chk("R1 latch after window", st_ol, 1);
    chk("R3 fault bit", fault_vec, 12'h008);
    chk("R5 detect pulls diag", diag_pull_low, 1);
    chk("R5 detect keeps outputs", ch_on, REQ);
    ol_raw[3] = 0; cyc(30);
    chk("R1 no early release", st_ol, 1);
    cyc(20);
    chk("R1 release after window", st_ol, 0);
    chk("R5 diag released", diag_pull_low, 0);
    chk("R3 fault held until read", fault_vec, 12'h008);
    pulse_fault_rd();
    chk("R3 fault cleared by read", fault_vec, 0);
  endtask

  task automatic t_detect_ext();
    ext_force = 1; cyc(60);
    chk("R5 ext force no flag", st_diagerr, 0);
    chk("R5 ext force no output change", ch_on, REQ);
    ext_force = 0; cyc(2);
  endtask

  task automatic t_diagen();
    diagen = 0; ol_raw[1] = 1; cyc(60);
    chk("R8 no diagnosis with diagen low", st_ol, 0);
    diagen = 1; cyc(55);
    chk("R8 latched with diagen high", st_ol, 1);
    ol_raw[1] = 0; diagen = 0; cyc(60);
    chk("R8 latch kept when diagen falls", st_ol, 1);
    diagen = 1; cyc(55);
    chk("R8 released after re-enable", st_ol, 0);
    pulse_fault_rd();
  endtask

  task automatic t_auto();
    int k;
    diag_mode = 2'b10; cyc(2);
    ol_raw[5] = 1; cyc(55);
    chk("R6 healthy off", ch_on, 0);
    chk("R6 faulty low current", ch_low_cur, 12'h020);
    chk("R6 diag pulled", diag_pull_low, 1);
    diag_mode = 2'b11; cyc(2);
    chk("R4 keep code holds auto", ch_low_cur, 12'h020);
    ol_raw[5] = 0;
    for (k = 0; k < 100; k++) begin
      cyc(1);
      if (!diag_pull_low) break;
    end
    chk("R6 diag released first", diag_pull_low, 0);
    chk("R6 outputs still off at release", ch_on, 0);
    cyc(1);
    chk("R6 normal resumes next cycle", ch_on, REQ);
    pulse_fault_rd();
  endtask

  task automatic t_auto_ext();
    ext_force = 1; cyc(55);
    chk("R7 diagerr latched", st_diagerr, 1);
    chk("R7 low power", low_power, 1);
    chk("R7 all off", ch_on, 0);
    ext_force = 0; cyc(55);
    chk("R7 diagerr released", st_diagerr, 0);
    chk("R7 outputs back", ch_on, REQ);
  endtask

  task automatic t_mode_none();
    diag_mode = 2'b00; cyc(2);
    ol_raw[7] = 1; cyc(60);
    chk("R4 mode 00 no diagnosis", st_ol, 0);
    ol_raw[7] = 0; cyc(2);
  endtask

  task automatic t_thermal();
    tw_cmp = 1; cyc(1); tw_cmp = 0; tw_cool = 1;
    chk("R2 warning set", st_tw, 1);
    cyc(10);
    chk("R2 warning held without read", st_tw, 1);
    status_rd = 1; cyc(1); status_rd = 0;
    chk("R2 warning cleared after read", st_tw, 0);
    tsd_cmp = 1; cyc(1);
    chk("R9 shutdown all off", ch_on, 0);
    chk("R9 shutdown pulls diag", diag_pull_low, 1);
    status_rd = 1; cyc(1); status_rd = 0; tsd_cmp = 0; cyc(10);
    chk("R2 shutdown held while hot", st_tsd, 1);
    tsd_cool = 1; cyc(1);
    chk("R2 shutdown cleared once cool", st_tsd, 0);
    chk("R9 outputs back", ch_on, REQ);
    tw_cool = 0; tsd_cool = 0;
  endtask

  task automatic t_uv_iset();
    uv = 1; #1;
    chk("R9 uv immediate off", ch_on, 0);
    chk("R10 st_uv", st_uv, 1);
    uv = 0; #1;
    chk("R9 uv release", ch_on, REQ);
    iset_short = 1; cyc(30);
    chk("R1 iset not yet", st_iset_sc, 0);
    cyc(20);
    chk("R1 iset latched", st_iset_sc, 1);
    chk("R9 iset off", ch_on, 0);
    chk("R9 iset pulls diag", diag_pull_low, 1);
    iset_short = 0; cyc(55);
    chk("R1 iset released", st_iset_sc, 0);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    t_reset();
    t_detect_filter();
    t_detect_ext();
    t_diagen();
    t_auto();
    t_auto_ext();
    t_mode_none();
    t_thermal();
    t_uv_iset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule